// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the bus-facing controller of a small byte-wide non-volatile memory. It watches an I2C bus (clock and data lines sampled by a faster system clock), recognises START and STOP, and answers to one 7-bit device address. After the address byte, a write transfer supplies a word address followed by data bytes. A read transfer returns data from an internal address counter. Memory content is held in a 256-byte register array.

Write data is gathered in a 16-entry page buffer. The array is only programmed when the host ends the write with STOP. That STOP starts an internal programming period of a parameterised number of clock cycles. During this period the device refuses its own address, so a host can poll by repeatedly sending the address until it is acknowledged. A write-lock input makes the array read-only. While it is high, the device still acknowledges the address and the word address, but it refuses the first data byte.

The block drives the data line only through an open-drain pull-down output. The host or the bench forms the wired-AND bus line.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data-line pull-down is off, the array holds 0x00 everywhere, and no internal write cycle is busy.
- R2: The first byte after START is the device byte: bits [7:1] are the device address (default 0x50) and bit 0 is the direction (0 = write, 1 = read). A matching byte is acknowledged by pulling SDA low during the ninth SCL pulse. A byte that does not match is not acknowledged.
- R3: A write transfer (device byte 0xA0, word address, one data byte, STOP) stores the byte at that word address once the internal write cycle ends.
- R4: Data bytes of a write go to consecutive buffer slots selected by the low 4 address bits. Past the end of a 16-byte page they wrap to the start of the same page, and the upper 4 address bits never change.
- R5: The internal write cycle starts only at a STOP that ends a write with at least one accepted data byte. A write ended by a repeated START programs nothing and starts no cycle.
- R6: For WRITE_CYCLES clock cycles after that STOP, the device byte is not acknowledged. Afterwards it is acknowledged again.
- R7: While the write-lock input is 1, the device byte and the word address are acknowledged, the first data byte is not, and nothing is programmed.
- R8: The address counter advances by one after every byte read or accepted for writing. A read with no preceding word address (device byte 0xA1) starts at the counter.
- R9: A random read (device byte 0xA0, word address, repeated START, device byte 0xA1) returns the byte at that word address.
- R10: In a read, each host acknowledge makes the next byte follow, with the address wrapping from 0xFF to 0x00. A host no-acknowledge followed by STOP ends the read.
- R11: SDA is sampled on SCL rising edges and the pull-down changes only while SCL is low. An SDA edge while SCL is high is a START or STOP, and it abandons any byte in progress and returns to waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| wr_lock_i | input | 1 | 1 makes the array read-only |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |

## Verification
The assertions check the following on every cycle:
- the pull-down only changes while the synchronised SCL is low;
- a START always releases the line;
- no device acknowledge is ever driven during the programming period;
- a programming cycle is never requested while one is already running;
- the page buffer holds data only during the data phase of a write;
- the bit counter stays within a nine-clock frame.

Only the bench scenarios can show that data reaches the array at the right addresses. This covers page wrap, sequential read wrap across 0xFF, the address counter after mixed reads and writes, and the effect of write lock. It also covers transfers abandoned by STOP or repeated START in the middle of a byte, and the polling sequence from refusal to acceptance.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_DECIDE,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_TXLOAD,
        ST_IGNORE
    } slv_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_WDATA
    } rx_kind_e;

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh_d, scl_sh_q;
    logic [STAGES-1:0] sda_sh_d, sda_sh_q;
    logic              scl_p_d, scl_p_q;
    logic              sda_p_d, sda_p_q;

    always_comb begin
        scl_sh_d = {scl_sh_q[STAGES-2:0], scl_i};
        sda_sh_d = {sda_sh_q[STAGES-2:0], sda_i};
        scl_p_d  = scl_sh_q[STAGES-1];
        sda_p_d  = sda_sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
            scl_p_q  <= scl_p_d;
            sda_p_q  <= sda_p_d;
        end
    end

    assign scl_o      = scl_sh_q[STAGES-1];
    assign sda_o      = sda_sh_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_p_q;
    assign scl_fall_o = ~scl_o & scl_p_q;
    assign start_o    = scl_o & scl_p_q & sda_p_q & ~sda_o;
    assign stop_o     = scl_o & scl_p_q & ~sda_p_q & sda_o;

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_W = 4,
    localparam int PAGE  = 1 << PAGE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [PAGE_W-1:0]       idx,
    input  logic [7:0]              wdata,
    input  logic                    clr,
    output logic [PAGE-1:0][7:0]    data_o,
    output logic [PAGE-1:0]         valid_o
);
    for (genvar s = 0; s < PAGE; s++) begin : g_slot
        logic [7:0] d_d, d_q;
        logic       v_d, v_q;
        logic       hit;

        assign hit = we && (idx == PAGE_W'(s));

        always_comb begin
            d_d = d_q;
            v_d = v_q;
            if (clr) begin
                v_d = 1'b0;
            end else if (hit) begin
                d_d = wdata;
                v_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else begin
                d_q <= d_d;
                v_q <= v_d;
            end
        end

        assign data_o[s]  = d_q;
        assign valid_o[s] = v_q;
    end

endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int PAGE  = 1 << PAGE_W,
    localparam int ROW_W = ADDR_W - PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [ROW_W-1:0]      page_sel,
    input  logic [PAGE-1:0][7:0]  pdata,
    input  logic [PAGE-1:0]       pmask,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (commit) begin
            for (int s = 0; s < PAGE; s++) begin
                if (pmask[s]) begin
                    mem_q[{page_sel, PAGE_W'(s)}] <= pdata[s];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
    parameter int CYCLES = 1000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_eeprom_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_W       = 4,
    parameter int         WRITE_CYCLES = 1000,
    parameter int         SYNC_STAGES  = 2,
    localparam int        PAGE         = 1 << PAGE_W,
    localparam int        ROW_W        = ADDR_W - PAGE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wr_lock_i,
    output logic sda_pull_o
);
    typedef struct packed {
        slv_state_e          st;
        rx_kind_e            kind;
        logic [3:0]          cnt;
        logic [7:0]          sh;
        logic [ADDR_W-1:0]   addr;
        logic                rd;
        logic                ack;
        logic                pull;
    } regs_t;

    regs_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, cyc_start, buf_we, buf_clr, buf_any, load_tx;
    logic [7:0] byte_in, rd_data;
    logic [PAGE-1:0][7:0] buf_data;
    logic [PAGE-1:0]      buf_valid;

    i2c_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    eeprom_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (buf_we),
        .idx     (q.addr[PAGE_W-1:0]),
        .wdata   (byte_in),
        .clr     (buf_clr),
        .data_o  (buf_data),
        .valid_o (buf_valid)
    );

    eeprom_cell_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (cyc_start),
        .page_sel (q.addr[ADDR_W-1:PAGE_W]),
        .pdata    (buf_data),
        .pmask    (buf_valid),
        .rd_addr  (q.addr),
        .rd_data  (rd_data)
    );

    eeprom_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cyc_start),
        .busy_o (busy)
    );

    assign buf_any = |buf_valid;
    assign buf_clr = start_det | stop_det;

    always_comb begin
        n         = q;
        byte_in   = {q.sh[6:0], sda_s};
        buf_we    = 1'b0;
        cyc_start = 1'b0;
        load_tx   = 1'b0;

        if (start_det) begin
            n.st   = ST_RX;
            n.kind = K_DEV;
            n.cnt  = '0;
            n.ack  = 1'b0;
            n.pull = 1'b0;
        end else if (stop_det) begin
            n.st      = ST_IDLE;
            n.cnt     = '0;
            n.pull    = 1'b0;
            cyc_start = buf_any;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh  = byte_in;
                        n.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            n.st = ST_DECIDE;
                            unique case (q.kind)
                                K_DEV: begin
                                    n.rd  = byte_in[0];
                                    n.ack = (byte_in[7:1] == DEV_ADDR) && !busy;
                                end
                                K_WADDR: begin
                                    n.ack  = 1'b1;
                                    n.addr = byte_in[ADDR_W-1:0];
                                end
                                default: begin
                                    n.ack = !wr_lock_i;
                                    if (!wr_lock_i) begin
                                        buf_we = 1'b1;
                                        n.addr[PAGE_W-1:0] = q.addr[PAGE_W-1:0] + 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_DECIDE: begin
                    if (scl_fall) begin
                        if (q.ack) begin
                            n.pull = 1'b1;
                            n.st   = ST_ACK;
                        end else begin
                            n.st = ST_IGNORE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.pull = 1'b0;
                        n.cnt  = '0;
                        if (q.kind == K_DEV && q.rd) begin
                            load_tx = 1'b1;
                        end else begin
                            n.st   = ST_RX;
                            n.kind = (q.kind == K_DEV) ? K_WADDR : K_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            n.pull = 1'b0;
                            n.st   = ST_HACK;
                        end else begin
                            n.sh   = {q.sh[6:0], 1'b0};
                            n.pull = ~q.sh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        n.st = sda_s ? ST_IGNORE : ST_TXLOAD;
                    end
                end
                ST_TXLOAD: begin
                    if (scl_fall) begin
                        load_tx = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (load_tx) begin
            n.sh   = rd_data;
            n.addr = q.addr + 1'b1;
            n.pull = ~rd_data[7];
            n.cnt  = '0;
            n.st   = ST_TX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: K_DEV, cnt: '0, sh: '0, addr: '0,
                   rd: 1'b0, ack: 1'b0, pull: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign sda_pull_o = q.pull;

    slv_state_e st_w;
    rx_kind_e   kind_w;
    logic [3:0] cnt_w;
    assign st_w   = q.st;
    assign kind_w = q.kind;
    assign cnt_w  = q.cnt;

endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk
    import i2c_eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       pull,
    input logic       busy,
    input logic       cyc_start,
    input logic       start_det,
    input logic       buf_any,
    input slv_state_e st,
    input rx_kind_e   kind,
    input logic [3:0] cnt
);
    // R11: pull-down moves only in the SCL low phase
    assert_pull_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull) |-> !scl_s);

    // R11: a START leaves the line released
    assert_start_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !pull);

    // R11: bit counter stays inside a nine-clock frame
    assert_bitcount_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 4'd8);

    // R6: no device acknowledge while programming
    assert_busy_no_dev_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(st == ST_ACK && kind == K_DEV));

    // R5: a new programming request never overlaps a running one
    assert_commit_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> !busy);

    // R4: buffered data exists only in the data phase of a write
    assert_buffer_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_any |-> kind == K_WDATA);

endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .pull      (sda_pull_o),
    .busy      (busy),
    .cyc_start (cyc_start),
    .start_det (start_det),
    .buf_any   (buf_any),
    .st        (st_w),
    .kind      (kind_w),
    .cnt       (cnt_w)
);

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WCYC       = 400;
    localparam logic [7:0] DEV_W = 8'hA0;
    localparam logic [7:0] DEV_R = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic lock = 1'b0;
    logic pull;
    logic sda_line;

    assign sda_line = sda_h & ~pull;

    i2c_eeprom_slave #(.DEV_ADDR(7'h50), .WRITE_CYCLES(WCYC)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .wr_lock_i  (lock),
        .sda_pull_o (pull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [7:0] v; string tag; } item_t;
    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] mdl [256];
    logic [7:0] ptr;

    task automatic expect_item(input logic [7:0] v, input string tag);
        item_t it;
        it.v = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: pops observed results and compares against expectations
    initial begin : monitor
        logic [7:0] o;
        item_t it;
        forever begin
            @(negedge clk);
            while (obs_q.size() != 0) begin
                o = obs_q.pop_front();
                n_run++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard: got %02h expected nothing", o);
                end else begin
                    it = exp_q.pop_front();
                    if (it.v !== o) begin
                        n_fail++;
                        $display("FAIL %s: got %02h expected %02h", it.tag, o, it.v);
                    end
                end
            end
        end
    end

    task automatic hold();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hold();
        scl = 1'b1;   hold();
        sda_h = 1'b0; hold();
        scl = 1'b0;   hold();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hold();
        scl = 1'b1;   hold();
        sda_h = 1'b1; hold();
    endtask

    task automatic put_bit(input logic b);
        sda_h = b;  hold();
        scl = 1'b1; hold();
        scl = 1'b0; hold();
    endtask

    task automatic get_bit(output logic b);
        sda_h = 1'b1; hold();
        scl = 1'b1;
        repeat (HALF/2) @(negedge clk);
        b = sda_line;
        repeat (HALF - HALF/2) @(negedge clk);
        scl = 1'b0; hold();
    endtask

    // send a byte; check slave acknowledge (1 = ACK)
    task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        expect_item({7'b0, exp_ack}, tag);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        obs_q.push_back({7'b0, ~a});
    endtask

    // receive a byte; host_ack = 1 asks for more
    task automatic recv(input logic [7:0] exp_v, input logic host_ack, input string tag);
        logic [7:0] b;
        logic bv;
        expect_item(exp_v, tag);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(bv);
            b = {b[6:0], bv};
        end
        put_bit(~host_ack);
        obs_q.push_back(b);
    endtask

    task automatic wait_write();
        repeat (WCYC + 50) @(negedge clk);
    endtask

    task automatic page_write(input logic [7:0] a, input int n, input logic [7:0] base, input string tag);
        logic [7:0] p;
        p = a;
        bus_start();
        send(DEV_W, 1'b1, "R2");
        send(a, 1'b1, tag);
        for (int i = 0; i < n; i++) begin
            send(base + 8'(i), 1'b1, tag);
            mdl[p] = base + 8'(i);
            p = {p[7:4], p[3:0] + 4'd1};
        end
        bus_stop();
        ptr = p;
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string tag);
        bus_start();
        send(DEV_W, 1'b1, tag);
        send(a, 1'b1, tag);
        bus_start();
        send(DEV_R, 1'b1, tag);
        for (int i = 0; i < n; i++) recv(mdl[a + 8'(i)], i != n - 1, tag);
        bus_stop();
        ptr = a + 8'(n);
    endtask

    task automatic cur_read(input int n, input string tag);
        bus_start();
        send(DEV_R, 1'b1, tag);
        for (int i = 0; i < n; i++) recv(mdl[ptr + 8'(i)], i != n - 1, tag);
        bus_stop();
        ptr = ptr + 8'(n);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        ptr = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: line released after reset
        expect_item(8'h00, "R1");
        obs_q.push_back({7'b0, pull});

        // R2: foreign device address refused
        bus_start();
        send(8'hA4, 1'b0, "R2");
        bus_stop();

        // R3 byte write, then R6 polling
        page_write(8'h10, 1, 8'hA5, "R3");
        bus_start();
        send(DEV_W, 1'b0, "R6");
        bus_stop();
        wait_write();
        bus_start();
        send(DEV_W, 1'b1, "R6");
        bus_stop();

        // R1: reset content 0 at untouched address, R9 random read
        rand_read(8'h11, 1, "R1");
        rand_read(8'h10, 1, "R9");

        // R4 page wrap within 0x20..0x2F
        page_write(8'h2C, 10, 8'h60, "R4");
        wait_write();
        rand_read(8'h20, 6, "R4");
        rand_read(8'h2C, 4, "R4");

        // R8 counter after read
        rand_read(8'h20, 3, "R9");
        cur_read(2, "R8");

        // R8 counter after write
        page_write(8'h72, 1, 8'hC3, "R3");
        wait_write();
        page_write(8'h70, 2, 8'h11, "R8");
        wait_write();
        cur_read(1, "R8");

        // R10 sequential wrap 0xFF -> 0x00
        page_write(8'hFE, 2, 8'hE0, "R4");
        wait_write();
        page_write(8'h00, 1, 8'h5C, "R3");
        wait_write();
        rand_read(8'hFE, 3, "R10");

        // R7 write lock
        lock = 1'b1;
        bus_start();
        send(DEV_W, 1'b1, "R7");
        send(8'h40, 1'b1, "R7");
        send(8'h77, 1'b0, "R7");
        bus_stop();
        lock = 1'b0;
        bus_start();
        send(DEV_W, 1'b1, "R7");
        bus_stop();
        rand_read(8'h40, 1, "R7");

        // R5 write ended by repeated START programs nothing
        bus_start();
        send(DEV_W, 1'b1, "R5");
        send(8'h50, 1'b1, "R5");
        send(8'h33, 1'b1, "R5");
        bus_start();
        send(DEV_R, 1'b1, "R5");
        recv(mdl[8'h51], 1'b0, "R8");
        bus_stop();
        bus_start();
        send(DEV_W, 1'b1, "R5");
        bus_stop();
        rand_read(8'h50, 1, "R5");

        // R11 abort by STOP and by START mid-byte
        page_write(8'h60, 1, 8'h9A, "R3");
        wait_write();
        bus_start();
        send(DEV_W, 1'b1, "R11");
        send(8'h60, 1'b1, "R11");
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
        bus_stop();
        bus_start();
        send(DEV_W, 1'b1, "R11");
        bus_stop();
        rand_read(8'h60, 1, "R11");
        bus_start();
        send(DEV_W, 1'b1, "R11");
        send(8'h60, 1'b1, "R11");
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send(DEV_R, 1'b1, "R11");
        recv(8'h9A, 1'b0, "R11");
        bus_stop();

        repeat (20) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule